// File: doc/BRIEF.md
# Connection Memory Nibble Block-Fill Engine

This controller loads one 4-bit value into bits 7:4 of every entry of a connection memory in a time-division switch, and leaves bits 3:0 of each entry as they were. A select register picks one of two memories: a large transmit-path memory or a smaller receive-path memory. One control write that sets the enable bit and carries the 4-bit value starts the fill. The enable bit reads back high while the fill is pending or running. The hardware clears it when the last entry has been written. The CPU can clear it at any time to abort.

The fill is paced by the TDM channel tick and aligned to the frame pulse. After the enable bit is set, the sweep waits for the first tick that carries a frame pulse. It then writes one entry per tick, and the address is the current channel position of the frame. If the ticks or the frame pulse never arrive, the enable bit stays high. If the framing jumps during a sweep, the entries that were jumped over stay unwritten. Each memory has a byte-wide write port with a per-nibble byte enable, so the lower nibble is kept without a read. CPU writes to a memory pass through the same port, and they are dropped while that memory is being filled.

Top module: `nibble_block_fill`

## Requirements
- R1: A control write with `reg_ctl_en`=1 while idle latches `reg_ctl_nib` and the current select value, and `fill_en_o` reads 1 from the next cycle.
- R2: Every fill write drives byte enable `2'b10` (bit 1 enables data bits 7:4, bit 0 enables bits 3:0) with the latched value in `wdata[7:4]`, so bits 3:0 of each entry keep their previous value.
- R3: Select value 0 targets the transmit memory (`TX_DEPTH` entries) and value 1 targets the receive memory (`RX_DEPTH` entries). A fill writes only the selected memory.
- R4: Ticks before the first tick with `tdm_frame`=1 write nothing. From that tick, each tick writes one entry at the channel position, starting at address 0. Each write appears on the memory port one cycle after its tick.
- R5: `fill_en_o` falls in the cycle after the tick that writes address depth-1, and stays high before that.
- R6: A control write with `reg_ctl_en`=0 ends a pending or running fill at that clock edge. No entry is written for a tick in the same cycle, and none after it.
- R7: Without pacing ticks, `fill_en_o` stays 1 for as long as the ticks are absent.
- R8: A tick with `tdm_frame`=1 during a sweep ends the fill with no write, and the addresses not yet reached keep their contents.
- R9: Changing the select register during a fill does not change the memory being filled. `sel_o` returns the new value.
- R10: A CPU memory write reaches the memory selected by `cpu_mem_tgt` (0 transmit, 1 receive) one cycle later with byte enable `2'b11`, unless that memory is being filled. In that case the write is dropped.
- R11: A control write with `reg_ctl_en`=1 during a fill is ignored, and the original value keeps being written.
- R12: A synchronous active-high reset clears the enable bit, the busy state and both write ports.
- R13: When a frame holds at least as many ticks as the target depth and a tick arrives every cycle, a fill started at any frame phase ends within two frame periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel_we | input | 1 | Write strobe for the select register |
| reg_sel_val | input | 1 | Select value: 0 transmit memory, 1 receive memory |
| reg_ctl_we | input | 1 | Write strobe for the control register |
| reg_ctl_en | input | 1 | Enable bit written: 1 start, 0 abort |
| reg_ctl_nib | input | 4 | Value loaded into bits 7:4 |
| fill_en_o | output | 1 | Enable bit readback, high while a fill is pending or running |
| sel_o | output | 1 | Select register readback |
| tdm_tick | input | 1 | Channel pacing tick |
| tdm_frame | input | 1 | Frame pulse, sampled with `tdm_tick` |
| cpu_mem_we | input | 1 | CPU memory write strobe |
| cpu_mem_tgt | input | 1 | CPU write target: 0 transmit, 1 receive |
| cpu_mem_addr | input | TX_AW | CPU write address |
| cpu_mem_data | input | 8 | CPU write data |
| tx_we | output | 1 | Transmit memory write strobe |
| tx_addr | output | TX_AW | Transmit memory address |
| tx_wdata | output | 8 | Transmit memory write data |
| tx_be | output | 2 | Transmit nibble enables (bit 1 high nibble) |
| rx_we | output | 1 | Receive memory write strobe |
| rx_addr | output | RX_AW | Receive memory address |
| rx_wdata | output | 8 | Receive memory write data |
| rx_be | output | 2 | Receive nibble enables (bit 1 high nibble) |

## Verification
Two events can land on the same clock edge: a pacing tick that would write the next entry, and a CPU action, either an abort or a CPU write to a memory. The bench drives these together on purpose. It raises the abort strobe in the same cycle as a sweep tick, and it raises CPU writes to the memory being filled and to the other memory in the same cycle as a fill tick. After each case it reads back a bench-held model of both memories. The abort tick must leave its entry unwritten, the CPU write to the busy memory must be dropped, and the CPU write to the idle memory must land in full.

// File: rtl/bfill_pkg.sv
package bfill_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ARMED = 2'd1,
        FS_SWEEP = 2'd2
    } fill_state_e;

    typedef enum logic {
        TGT_TX = 1'b0,
        TGT_RX = 1'b1
    } fill_tgt_e;

    localparam logic [1:0] BE_HI  = 2'b10;
    localparam logic [1:0] BE_ALL = 2'b11;

    typedef struct packed {
        fill_state_e state;
        fill_tgt_e   tgt;
        logic [3:0]  nib;
    } seq_reg_t;

    typedef struct packed {
        logic sel;
    } top_reg_t;

endpackage

// File: rtl/bfill_framer.sv
module bfill_framer #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             frame_i,
    output logic [POS_W-1:0] chan_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } frm_reg_t;

    frm_reg_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        chan_o = frame_i ? '0 : r_q.pos;
        if (tick_i) begin
            r_d.pos = (chan_o == POS_MAX) ? POS_MAX : chan_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assert_pos_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> (r_q.pos == $past(r_q.pos)));

endmodule

// File: rtl/bfill_seq.sv
module bfill_seq
    import bfill_pkg::*;
#(
    parameter int TX_DEPTH = 2430,
    parameter int RX_DEPTH = 512,
    parameter int POS_W    = 12,
    parameter int AW       = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we_i,
    input  logic             ctl_en_i,
    input  logic [3:0]       ctl_nib_i,
    input  logic             sel_i,
    input  logic             tick_i,
    input  logic             frame_i,
    input  logic [POS_W-1:0] chan_i,
    output logic             busy_o,
    output fill_tgt_e        tgt_o,
    output logic             fill_we_o,
    output logic [AW-1:0]    fill_addr_o,
    output logic [3:0]       fill_nib_o
);
    localparam logic [POS_W-1:0] TX_LAST = POS_W'(TX_DEPTH - 1);
    localparam logic [POS_W-1:0] RX_LAST = POS_W'(RX_DEPTH - 1);

    seq_reg_t         r_q, r_d;
    logic             abort;
    logic [POS_W-1:0] last;

    always_comb begin
        r_d       = r_q;
        fill_we_o = 1'b0;
        abort     = ctl_we_i && !ctl_en_i;
        last      = (r_q.tgt == TGT_RX) ? RX_LAST : TX_LAST;
        unique case (r_q.state)
            FS_IDLE: begin
                if (ctl_we_i && ctl_en_i) begin
                    r_d.state = FS_ARMED;
                    r_d.tgt   = fill_tgt_e'(sel_i);
                    r_d.nib   = ctl_nib_i;
                end
            end
            FS_ARMED: begin
                if (abort) begin
                    r_d.state = FS_IDLE;
                end else if (tick_i && frame_i) begin
                    fill_we_o = 1'b1;
                    r_d.state = (chan_i == last) ? FS_IDLE : FS_SWEEP;
                end
            end
            FS_SWEEP: begin
                if (abort) begin
                    r_d.state = FS_IDLE;
                end else if (tick_i) begin
                    if (frame_i) begin
                        r_d.state = FS_IDLE;
                    end else begin
                        fill_we_o = 1'b1;
                        if (chan_i == last) r_d.state = FS_IDLE;
                    end
                end
            end
            default: r_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: FS_IDLE, tgt: TGT_TX, nib: 4'h0};
        else     r_q <= r_d;
    end

    assign busy_o      = (r_q.state != FS_IDLE);
    assign tgt_o       = r_q.tgt;
    assign fill_nib_o  = r_q.nib;
    assign fill_addr_o = AW'(chan_i);

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        fill_we_o |-> (chan_i <= last));

    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_we_i && !ctl_en_i) |=> !busy_o);

    assert_tgt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || $stable(r_q.tgt)));

    assert_nib_hold_R11: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || $stable(r_q.nib)));

    assert_no_pace_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !tick_i && !abort) |=> busy_o);

endmodule

// File: rtl/bfill_port.sv
module bfill_port
    import bfill_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic          fill_we_i,
    input  logic [AW-1:0] fill_addr_i,
    input  logic [3:0]    fill_nib_i,
    input  logic          cpu_we_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [7:0]    cpu_data_i,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    wdata_o,
    output logic [1:0]    be_o
);
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [1:0]    be;
    } port_reg_t;

    port_reg_t p_q, p_d;

    always_comb begin
        p_d = '0;
        if (fill_we_i) begin
            p_d.we   = 1'b1;
            p_d.addr = fill_addr_i;
            p_d.data = {fill_nib_i, 4'h0};
            p_d.be   = BE_HI;
        end else if (cpu_we_i && !busy_i) begin
            p_d.we   = 1'b1;
            p_d.addr = cpu_addr_i;
            p_d.data = cpu_data_i;
            p_d.be   = BE_ALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign we_o    = p_q.we;
    assign addr_o  = p_q.addr;
    assign wdata_o = p_q.data;
    assign be_o    = p_q.be;

    assert_cpu_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (we_o && be_o == BE_ALL) |-> !$past(busy_i));

    assert_fill_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        (we_o && be_o == BE_HI) |-> ($past(fill_we_i) && wdata_o[7:4] == $past(fill_nib_i)));

endmodule

// File: rtl/nibble_block_fill.sv
module nibble_block_fill
    import bfill_pkg::*;
#(
    parameter int TX_DEPTH = 2430,
    parameter int RX_DEPTH = 512,
    parameter int POS_W    = 12,
    localparam int TX_AW   = $clog2(TX_DEPTH),
    localparam int RX_AW   = $clog2(RX_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel_we,
    input  logic             reg_sel_val,
    input  logic             reg_ctl_we,
    input  logic             reg_ctl_en,
    input  logic [3:0]       reg_ctl_nib,
    output logic             fill_en_o,
    output logic             sel_o,
    input  logic             tdm_tick,
    input  logic             tdm_frame,
    input  logic             cpu_mem_we,
    input  logic             cpu_mem_tgt,
    input  logic [TX_AW-1:0] cpu_mem_addr,
    input  logic [7:0]       cpu_mem_data,
    output logic             tx_we,
    output logic [TX_AW-1:0] tx_addr,
    output logic [7:0]       tx_wdata,
    output logic [1:0]       tx_be,
    output logic             rx_we,
    output logic [RX_AW-1:0] rx_addr,
    output logic [7:0]       rx_wdata,
    output logic [1:0]       rx_be
);
    top_reg_t         t_q, t_d;
    logic [POS_W-1:0] chan;
    logic             busy;
    fill_tgt_e        tgt;
    logic             fill_we;
    logic [TX_AW-1:0] fill_addr;
    logic [3:0]       fill_nib;
    logic             busy_tx, busy_rx;

    always_comb begin
        t_d = t_q;
        if (reg_sel_we) t_d.sel = reg_sel_val;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign sel_o     = t_q.sel;
    assign fill_en_o = busy;
    assign busy_tx   = busy && (tgt == TGT_TX);
    assign busy_rx   = busy && (tgt == TGT_RX);

    bfill_framer #(.POS_W(POS_W)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tdm_tick),
        .frame_i (tdm_frame),
        .chan_o  (chan)
    );

    bfill_seq #(
        .TX_DEPTH (TX_DEPTH),
        .RX_DEPTH (RX_DEPTH),
        .POS_W    (POS_W),
        .AW       (TX_AW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctl_we_i    (reg_ctl_we),
        .ctl_en_i    (reg_ctl_en),
        .ctl_nib_i   (reg_ctl_nib),
        .sel_i       (t_q.sel),
        .tick_i      (tdm_tick),
        .frame_i     (tdm_frame),
        .chan_i      (chan),
        .busy_o      (busy),
        .tgt_o       (tgt),
        .fill_we_o   (fill_we),
        .fill_addr_o (fill_addr),
        .fill_nib_o  (fill_nib)
    );

    bfill_port #(.AW(TX_AW)) u_port_tx (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy_tx),
        .fill_we_i   (fill_we && (tgt == TGT_TX)),
        .fill_addr_i (fill_addr),
        .fill_nib_i  (fill_nib),
        .cpu_we_i    (cpu_mem_we && !cpu_mem_tgt),
        .cpu_addr_i  (cpu_mem_addr),
        .cpu_data_i  (cpu_mem_data),
        .we_o        (tx_we),
        .addr_o      (tx_addr),
        .wdata_o     (tx_wdata),
        .be_o        (tx_be)
    );

    bfill_port #(.AW(RX_AW)) u_port_rx (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy_rx),
        .fill_we_i   (fill_we && (tgt == TGT_RX)),
        .fill_addr_i (RX_AW'(fill_addr)),
        .fill_nib_i  (fill_nib),
        .cpu_we_i    (cpu_mem_we && cpu_mem_tgt),
        .cpu_addr_i  (RX_AW'(cpu_mem_addr)),
        .cpu_data_i  (cpu_mem_data),
        .we_o        (rx_we),
        .addr_o      (rx_addr),
        .wdata_o     (rx_wdata),
        .be_o        (rx_be)
    );

    assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
        !(tx_we && tx_be == BE_HI && rx_we && rx_be == BE_HI));

    assert_en_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_en_o) |-> $past(tdm_tick || (reg_ctl_we && !reg_ctl_en)));

    assert_start_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_ctl_we && reg_ctl_en) |=> fill_en_o);

endmodule

// File: tb/nibble_block_fill_tb.sv
module nibble_block_fill_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TX_DEPTH   = 12;
    localparam int RX_DEPTH   = 5;
    localparam int POS_W      = 5;
    localparam int FRAME_LEN  = 16;
    localparam int TX_AW      = $clog2(TX_DEPTH);
    localparam int RX_AW      = $clog2(RX_DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_we = 0, sel_val = 0, ctl_we = 0, ctl_en = 0;
    logic [3:0] ctl_nib = 0;
    logic tick = 0, frame = 0, mw = 0, mtgt = 0;
    logic [TX_AW-1:0] maddr = 0;
    logic [7:0] mdata = 0;
    logic fill_en, sel_rd;
    logic tx_we, rx_we;
    logic [TX_AW-1:0] tx_addr;
    logic [RX_AW-1:0] rx_addr;
    logic [7:0] tx_wdata, rx_wdata;
    logic [1:0] tx_be, rx_be;
    logic load = 0;

    logic [7:0] txm [TX_DEPTH];
    logic [7:0] rxm [RX_DEPTH];
    logic [7:0] exp_tx [TX_DEPTH];
    logic [7:0] exp_rx [RX_DEPTH];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_block_fill #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .POS_W(POS_W)) u_dut (
        .clk(clk), .rst(rst),
        .reg_sel_we(sel_we), .reg_sel_val(sel_val),
        .reg_ctl_we(ctl_we), .reg_ctl_en(ctl_en), .reg_ctl_nib(ctl_nib),
        .fill_en_o(fill_en), .sel_o(sel_rd),
        .tdm_tick(tick), .tdm_frame(frame),
        .cpu_mem_we(mw), .cpu_mem_tgt(mtgt), .cpu_mem_addr(maddr), .cpu_mem_data(mdata),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_be(tx_be),
        .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_be(rx_be)
    );

    // Bench-held memories: bit 1 of be enables bits 7:4, bit 0 bits 3:0.
    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < TX_DEPTH; i++) txm[i] <= 8'(i * 7 + 3);
            for (int i = 0; i < RX_DEPTH; i++) rxm[i] <= 8'(i * 11 + 5);
        end else begin
            if (tx_we && int'(tx_addr) < TX_DEPTH) begin
                if (tx_be[1]) txm[tx_addr][7:4] <= tx_wdata[7:4];
                if (tx_be[0]) txm[tx_addr][3:0] <= tx_wdata[3:0];
            end
            if (rx_we && int'(rx_addr) < RX_DEPTH) begin
                if (rx_be[1]) rxm[rx_addr][7:4] <= rx_wdata[7:4];
                if (rx_be[0]) rxm[rx_addr][3:0] <= rx_wdata[3:0];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        sel_we = 0; ctl_we = 0; tick = 0; frame = 0; mw = 0; load = 0;
    endtask

    task automatic tk(input bit f);
        tick = 1; frame = f; cyc();
    endtask

    task automatic pick(input bit v);
        sel_we = 1; sel_val = v; cyc();
    endtask

    task automatic start(input logic [3:0] n);
        ctl_we = 1; ctl_en = 1; ctl_nib = n; cyc();
    endtask

    task automatic exp_fill(input bit rx, input logic [3:0] n, input int lo, input int hi);
        for (int a = lo; a <= hi; a++) begin
            if (rx) exp_rx[a][7:4] = n;
            else    exp_tx[a][7:4] = n;
        end
    endtask

    task automatic check_mems(input string req);
        cyc(); cyc();
        for (int a = 0; a < TX_DEPTH; a++) chk(txm[a] == exp_tx[a], req, txm[a], exp_tx[a]);
        for (int a = 0; a < RX_DEPTH; a++) chk(rxm[a] == exp_rx[a], req, rxm[a], exp_rx[a]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        int ph;
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(fill_en == 0, "R12 enable", fill_en, 0);
        chk(tx_we == 0 && rx_we == 0, "R12 ports", {tx_we, rx_we}, 0);
        rst = 0;
        load = 1; cyc();
        for (int i = 0; i < TX_DEPTH; i++) exp_tx[i] = 8'(i * 7 + 3);
        for (int i = 0; i < RX_DEPTH; i++) exp_rx[i] = 8'(i * 11 + 5);
        check_mems("R12 preload");

        // R1 R4 R5 R2 R3: full transmit fill
        pick(0);
        start(4'hA);
        chk(fill_en == 1, "R1 enable set", fill_en, 1);
        for (int i = 0; i < 5; i++) tk(0);
        chk(fill_en == 1, "R4 waits frame", fill_en, 1);
        check_mems("R4 no write before frame");
        tk(1);
        chk(tx_we == 1 && tx_addr == 0, "R4 first address", int'(tx_addr), 0);
        chk(tx_be == 2'b10 && tx_wdata[7:4] == 4'hA, "R2 nibble enable", {tx_be, tx_wdata}, {2'b10, 8'hA0});
        chk(rx_we == 0, "R3 other port idle", rx_we, 0);
        for (int c = 1; c < TX_DEPTH - 1; c++) tk(0);
        chk(fill_en == 1, "R5 high before last", fill_en, 1);
        tk(0);
        chk(fill_en == 0, "R5 cleared after last", fill_en, 0);
        chk(tx_addr == TX_AW'(TX_DEPTH - 1), "R4 last address", int'(tx_addr), TX_DEPTH - 1);
        exp_fill(0, 4'hA, 0, TX_DEPTH - 1);
        check_mems("R2 R3 transmit fill");

        // R7: no pacing, then receive fill
        pick(1);
        start(4'h3);
        repeat (40) cyc();
        chk(fill_en == 1, "R7 held without ticks", fill_en, 1);
        tk(1);
        for (int c = 1; c < RX_DEPTH; c++) tk(0);
        chk(fill_en == 0, "R5 receive done", fill_en, 0);
        exp_fill(1, 4'h3, 0, RX_DEPTH - 1);
        check_mems("R3 receive fill");

        // R6: abort in the same cycle as a tick
        pick(0);
        start(4'h5);
        tk(1); tk(0); tk(0);
        tick = 1; ctl_we = 1; ctl_en = 0; cyc();
        chk(fill_en == 0, "R6 abort clears", fill_en, 0);
        tk(0); tk(0); tk(0); tk(1); tk(0);
        chk(fill_en == 0, "R6 stays idle", fill_en, 0);
        exp_fill(0, 4'h5, 0, 2);
        check_mems("R6 abort");

        // R8: frame jump during a sweep
        pick(1);
        start(4'h9);
        tk(1); tk(0); tk(1);
        chk(fill_en == 0, "R8 jump ends fill", fill_en, 0);
        tk(0); tk(0); tk(0);
        exp_fill(1, 4'h9, 0, 1);
        check_mems("R8 skipped entries");

        // R9 R10 R11: select change, CPU collisions, restart ignored
        pick(0);
        start(4'h6);
        pick(1);
        chk(sel_rd == 1, "R9 select readback", sel_rd, 1);
        tk(1);
        tick = 1; mw = 1; mtgt = 0; maddr = 3; mdata = 8'hFF; cyc();
        tick = 1; mw = 1; mtgt = 1; maddr = 2; mdata = 8'h5C; cyc();
        chk(rx_we == 1 && rx_be == 2'b11 && rx_wdata == 8'h5C, "R10 idle memory write", rx_wdata, 8'h5C);
        exp_rx[2] = 8'h5C;
        tick = 1; ctl_we = 1; ctl_en = 1; ctl_nib = 4'h2; cyc();
        chk(tx_wdata[7:4] == 4'h6, "R11 value kept", tx_wdata[7:4], 6);
        for (int c = 4; c < TX_DEPTH; c++) tk(0);
        chk(fill_en == 0, "R9 fill done", fill_en, 0);
        exp_fill(0, 4'h6, 0, TX_DEPTH - 1);
        check_mems("R9 R10 R11 collisions");
        mw = 1; mtgt = 0; maddr = 3; mdata = 8'h81; cyc();
        chk(tx_we == 1 && tx_be == 2'b11 && tx_addr == 3, "R10 write after fill", {tx_be, 4'(tx_addr)}, {2'b11, 4'd3});
        exp_tx[3] = 8'h81;
        check_mems("R10 full byte");

        // R13: free-running pacing, start mid-frame
        pick(0);
        start(4'hC);
        ph = 5; n = 0;
        while (fill_en && n < 100) begin
            tick = 1; frame = (ph == 0); cyc();
            ph = (ph + 1) % FRAME_LEN;
            n++;
        end
        chk(n <= 2 * FRAME_LEN, "R13 bound", n, 2 * FRAME_LEN);
        chk(n == (FRAME_LEN - 5) + TX_DEPTH, "R13 tick count", n, (FRAME_LEN - 5) + TX_DEPTH);
        exp_fill(0, 4'hC, 0, TX_DEPTH - 1);
        check_mems("R13 fill");

        // R2 R3: sweep every nibble value over the receive memory
        pick(1);
        for (int v = 0; v < 16; v++) begin
            start(4'(v));
            tk(1);
            for (int c = 1; c < RX_DEPTH; c++) tk(0);
            chk(fill_en == 0, "R5 sweep done", fill_en, 0);
            exp_fill(1, 4'(v), 0, RX_DEPTH - 1);
            check_mems("R2 nibble sweep");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule